// File: doc/BRIEF.md
# Outbound Address Translation Table

This block sits beside the slave port of an on-chip bus bridge and rewrites each incoming request address into the address space of the serial link. It holds a small set of programmable windows. Each window has an enable, a source base aligned to 4 KiB, a power-of-two size, a translated base and a parameter word. An address that falls inside an enabled window has its upper bits replaced by the window's translated base. The block returns a hit flag, the rewritten address, the window's request type (memory or configuration), a direction flag and the number of the window that matched.

Software fills the windows through a 32-bit word-addressed register port. Writes take effect on the clock edge that captures them. The lookup path is pure logic from the request address to the outputs, so the bridge can add its own pipeline stage wherever its timing needs one. Request data and packet formation are handled elsewhere.

Top module: `axi_pcie_atu`

## Requirements
- R1: After reset every window is disabled, every register reads zero, `hit_o` is low and `xlat_addr_o` equals `axi_addr_i`.
- R2: Window n occupies byte offsets 0x800 + 0x20·n. Within a window, the source base low word is at +0x0, the source base high word at +0x4, the translated base low word at +0x8, the translated base high word at +0xC and the parameter word at +0x10. Every one of these registers reads back what was written, apart from the bits that R3 forces to zero.
- R3: In the source low word, bit 0 is the enable, bits 6:1 are the size field S and bits 31:12 are the base. Bits 11:7 always read zero. In the translated low word, bits 11:0 always read zero.
- R4: A window hits when it is enabled and address bits S+1 and above equal the same bits of its source base. The window therefore covers 2^(S+1) bytes.
- R5: On a hit, output bits S+1 and above come from the translated base, and bits S down to 0 are copied from the input address.
- R6: A window whose enable bit is zero never hits, whatever its other fields hold.
- R7: When several windows hit, the one with the lowest number drives the outputs, and `xlat_entry_o` gives its number.
- R8: When no window hits, `hit_o` is low, `xlat_addr_o` equals the input address, and `xlat_id_o`, `xlat_dir_o` and `xlat_entry_o` are zero.
- R9: On a hit, `xlat_id_o` equals bits 3:0 of the matching window's parameter word. The value 0 means a memory request and 1 means a configuration request. `xlat_dir_o` equals bit 22 of that parameter word.
- R10: Lookup is combinational. A register write changes the lookup result and the read data only from the clock edge that captures it onward.
- R11: A 256 MiB configuration window (S = 27) that translates to base 0 maps every address inside it to its offset within the window, with ID 1.
- R12: A write to an offset outside the table, or to an unused word inside a window, changes no register and no lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 12 | Byte offset of the register write |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_addr | input | 12 | Byte offset of the register read |
| cfg_rd_data | output | 32 | Register read data, combinational |
| axi_addr_i | input | 64 | Request address to translate |
| hit_o | output | 1 | A window matched |
| xlat_addr_o | output | 64 | Translated address, or the input address on a miss |
| xlat_id_o | output | 4 | Request type of the matching window |
| xlat_dir_o | output | 1 | Direction flag of the matching window |
| xlat_entry_o | output | 3 | Number of the matching window |

## Verification
The lookup outputs and the read data depend on their inputs through logic alone. The bench therefore applies an address or read offset and samples one nanosecond later, within the same clock phase. A register write is driven at a falling edge and counts from the next rising edge. Lookups and readbacks that follow a write are sampled after that edge, at the next falling edge. The latency test holds a write and a matching address together, samples once before the capturing edge, where a miss is due, and once after it, where a hit is due.

// File: rtl/atu_pkg.sv
package atu_pkg;

   // register word selected inside one window
   typedef enum logic [2:0] {
      FLD_SRC_LO  = 3'd0,
      FLD_SRC_HI  = 3'd1,
      FLD_TRSL_LO = 3'd2,
      FLD_TRSL_HI = 3'd3,
      FLD_PARAM   = 3'd4,
      FLD_NONE    = 3'd7
   } atu_field_e;

   localparam int unsigned REG_W     = 32;
   localparam int unsigned EN_BIT    = 0;
   localparam int unsigned SIZE_LSB  = 1;
   localparam int unsigned SIZE_W    = 6;
   localparam int unsigned PAGE_LSB  = 12;
   localparam int unsigned PAGE_W    = REG_W - PAGE_LSB;

   // word offset inside a window -> field
   function automatic atu_field_e word_to_field(input logic [4:0] off);
      case (off)
         5'h00:   return FLD_SRC_LO;
         5'h04:   return FLD_SRC_HI;
         5'h08:   return FLD_TRSL_LO;
         5'h0C:   return FLD_TRSL_HI;
         5'h10:   return FLD_PARAM;
         default: return FLD_NONE;
      endcase
   endfunction

endpackage

// File: rtl/atu_reg_decode.sv
module atu_reg_decode
   import atu_pkg::*;
#(
   parameter int unsigned CFG_AW       = 12,
   parameter int unsigned NUM_ENTRIES  = 8,
   parameter int unsigned TABLE_BASE   = 'h800,
   parameter int unsigned STRIDE_LOG2  = 5,
   parameter int unsigned IDX_W        = 3
) (
   input  logic [CFG_AW-1:0] addr_i,
   output logic              in_table_o,
   output logic [IDX_W-1:0]  idx_o,
   output atu_field_e        field_o
);

   localparam int unsigned TABLE_END = TABLE_BASE + (NUM_ENTRIES << STRIDE_LOG2);

   logic [CFG_AW:0] offset;

   always_comb begin
      offset     = {1'b0, addr_i} - (CFG_AW+1)'(TABLE_BASE);
      in_table_o = ({1'b0, addr_i} >= (CFG_AW+1)'(TABLE_BASE)) &&
                   ({1'b0, addr_i} <  (CFG_AW+1)'(TABLE_END));
      idx_o      = offset[STRIDE_LOG2 +: IDX_W];
      field_o    = in_table_o ? word_to_field(offset[4:0]) : FLD_NONE;
   end

endmodule

// File: rtl/atu_entry.sv
module atu_entry
   import atu_pkg::*;
#(
   parameter int unsigned ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb_i,
   input  atu_field_e        wr_field_i,
   input  logic [REG_W-1:0]  wr_data_i,
   input  atu_field_e        rd_field_i,
   output logic [REG_W-1:0]  rd_word_o,
   input  logic [ADDR_W-1:0] lookup_addr_i,
   output logic              match_o,
   output logic [ADDR_W-1:0] xlat_o,
   output logic [REG_W-1:0]  param_o
);

   localparam int unsigned HI_W = ADDR_W - REG_W;

   logic              en_q;
   logic [SIZE_W-1:0] size_q;
   logic [PAGE_W-1:0] src_lo_q;
   logic [HI_W-1:0]   src_hi_q;
   logic [PAGE_W-1:0] trsl_lo_q;
   logic [HI_W-1:0]   trsl_hi_q;
   logic [REG_W-1:0]  param_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         size_q    <= '0;
         src_lo_q  <= '0;
         src_hi_q  <= '0;
         trsl_lo_q <= '0;
         trsl_hi_q <= '0;
         param_q   <= '0;
      end else if (wr_stb_i) begin
         case (wr_field_i)
            FLD_SRC_LO: begin
               en_q     <= wr_data_i[EN_BIT];
               size_q   <= wr_data_i[SIZE_LSB +: SIZE_W];
               src_lo_q <= wr_data_i[PAGE_LSB +: PAGE_W];
            end
            FLD_SRC_HI:  src_hi_q  <= wr_data_i[HI_W-1:0];
            FLD_TRSL_LO: trsl_lo_q <= wr_data_i[PAGE_LSB +: PAGE_W];
            FLD_TRSL_HI: trsl_hi_q <= wr_data_i[HI_W-1:0];
            FLD_PARAM:   param_q   <= wr_data_i;
            default: ;
         endcase
      end
   end

   // readback with reserved bits forced to zero
   always_comb begin
      rd_word_o = '0;
      case (rd_field_i)
         FLD_SRC_LO: begin
            rd_word_o[EN_BIT]                 = en_q;
            rd_word_o[SIZE_LSB +: SIZE_W]     = size_q;
            rd_word_o[PAGE_LSB +: PAGE_W]     = src_lo_q;
         end
         FLD_SRC_HI:  rd_word_o[HI_W-1:0]         = src_hi_q;
         FLD_TRSL_LO: rd_word_o[PAGE_LSB +: PAGE_W] = trsl_lo_q;
         FLD_TRSL_HI: rd_word_o[HI_W-1:0]         = trsl_hi_q;
         FLD_PARAM:   rd_word_o                   = param_q;
         default: ;
      endcase
   end

   // window compare: bits above S take part, bits S..0 pass through
   logic [ADDR_W-1:0] src_full;
   logic [ADDR_W-1:0] trsl_full;
   logic [ADDR_W-1:0] cmp_mask;

   always_comb begin
      src_full  = {src_hi_q, src_lo_q, {PAGE_LSB{1'b0}}};
      trsl_full = {trsl_hi_q, trsl_lo_q, {PAGE_LSB{1'b0}}};
      for (int i = 0; i < int'(ADDR_W); i++) begin
         cmp_mask[i] = (i > int'(size_q));
      end
      match_o = en_q && (((lookup_addr_i ^ src_full) & cmp_mask) == '0);
      xlat_o  = (trsl_full & cmp_mask) | (lookup_addr_i & ~cmp_mask);
   end

   assign param_o = param_q;

endmodule

// File: rtl/atu_prio_sel.sv
module atu_prio_sel #(
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned IDX_W       = 3
) (
   input  logic [NUM_ENTRIES-1:0] req_i,
   output logic                   any_o,
   output logic [IDX_W-1:0]       idx_o
);

   // lowest-numbered request wins; scan from the top so the lowest overwrites last
   always_comb begin
      any_o = |req_i;
      idx_o = '0;
      for (int i = int'(NUM_ENTRIES) - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/axi_pcie_atu.sv
module axi_pcie_atu
   import atu_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned ADDR_W      = 64,
   parameter int unsigned CFG_AW      = 12,
   parameter int unsigned TABLE_BASE  = 'h800,
   parameter int unsigned STRIDE_LOG2 = 5,
   parameter int unsigned ID_W        = 4,
   parameter int unsigned DIR_BIT     = 22,
   localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [CFG_AW-1:0] cfg_wr_addr,
   input  logic [31:0]       cfg_wr_data,
   input  logic [CFG_AW-1:0] cfg_rd_addr,
   output logic [31:0]       cfg_rd_data,
   input  logic [ADDR_W-1:0] axi_addr_i,
   output logic              hit_o,
   output logic [ADDR_W-1:0] xlat_addr_o,
   output logic [ID_W-1:0]   xlat_id_o,
   output logic              xlat_dir_o,
   output logic [IDX_W-1:0]  xlat_entry_o
);

   // elaboration checks
   if (ADDR_W <= REG_W || ADDR_W > 2 * REG_W) begin : g_bad_addr_w
      $error("ADDR_W must lie in 33..64");
   end
   if (STRIDE_LOG2 < 5) begin : g_bad_stride
      $error("window stride must hold five words");
   end
   if (ID_W == 0 || ID_W > DIR_BIT || DIR_BIT >= REG_W) begin : g_bad_param_fields
      $error("ID and direction fields must be disjoint inside the parameter word");
   end
   if (TABLE_BASE + (NUM_ENTRIES << STRIDE_LOG2) > (1 << CFG_AW)) begin : g_bad_map
      $error("table does not fit the register space");
   end

   // register address decode, one instance per access direction
   logic       wr_in_table, rd_in_table;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   atu_field_e wr_field, rd_field;

   atu_reg_decode #(
      .CFG_AW(CFG_AW), .NUM_ENTRIES(NUM_ENTRIES), .TABLE_BASE(TABLE_BASE),
      .STRIDE_LOG2(STRIDE_LOG2), .IDX_W(IDX_W)
   ) u_wr_dec (
      .addr_i(cfg_wr_addr), .in_table_o(wr_in_table), .idx_o(wr_idx), .field_o(wr_field)
   );

   atu_reg_decode #(
      .CFG_AW(CFG_AW), .NUM_ENTRIES(NUM_ENTRIES), .TABLE_BASE(TABLE_BASE),
      .STRIDE_LOG2(STRIDE_LOG2), .IDX_W(IDX_W)
   ) u_rd_dec (
      .addr_i(cfg_rd_addr), .in_table_o(rd_in_table), .idx_o(rd_idx), .field_o(rd_field)
   );

   // window array
   logic [NUM_ENTRIES-1:0] match_vec;
   logic [ADDR_W-1:0]      xlat_arr  [NUM_ENTRIES];
   logic [REG_W-1:0]       param_arr [NUM_ENTRIES];
   logic [REG_W-1:0]       rd_arr    [NUM_ENTRIES];

   for (genvar g = 0; g < int'(NUM_ENTRIES); g++) begin : g_entry
      logic stb;
      assign stb = cfg_wr_en && wr_in_table && (wr_field != FLD_NONE) &&
                   (wr_idx == IDX_W'(g));

      atu_entry #(.ADDR_W(ADDR_W)) u_entry (
         .clk           (clk),
         .rst_n         (rst_n),
         .wr_stb_i      (stb),
         .wr_field_i    (wr_field),
         .wr_data_i     (cfg_wr_data),
         .rd_field_i    (rd_field),
         .rd_word_o     (rd_arr[g]),
         .lookup_addr_i (axi_addr_i),
         .match_o       (match_vec[g]),
         .xlat_o        (xlat_arr[g]),
         .param_o       (param_arr[g])
      );
   end

   // register readback
   always_comb begin
      cfg_rd_data = '0;
      if (rd_in_table && rd_field != FLD_NONE) cfg_rd_data = rd_arr[rd_idx];
   end

   // priority select and output steering
   logic             any_hit;
   logic [IDX_W-1:0] win_idx;

   atu_prio_sel #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_prio (
      .req_i (match_vec),
      .any_o (any_hit),
      .idx_o (win_idx)
   );

   always_comb begin
      hit_o        = any_hit;
      xlat_addr_o  = axi_addr_i;
      xlat_id_o    = '0;
      xlat_dir_o   = 1'b0;
      xlat_entry_o = '0;
      if (any_hit) begin
         xlat_addr_o  = xlat_arr[win_idx];
         xlat_id_o    = param_arr[win_idx][ID_W-1:0];
         xlat_dir_o   = param_arr[win_idx][DIR_BIT];
         xlat_entry_o = win_idx;
      end
   end

endmodule

// File: rtl/atu_checker.sv
module atu_checker #(
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned ADDR_W      = 64,
   parameter int unsigned CFG_AW      = 12,
   parameter int unsigned TABLE_BASE  = 'h800,
   parameter int unsigned STRIDE_LOG2 = 5,
   parameter int unsigned IDX_W       = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   wr_en,
   input logic [CFG_AW-1:0]      rd_addr,
   input logic [31:0]            rd_data,
   input logic [ADDR_W-1:0]      axi_addr,
   input logic                   hit,
   input logic [ADDR_W-1:0]      xlat_addr,
   input logic [IDX_W-1:0]       hit_entry,
   input logic [NUM_ENTRIES-1:0] match_vec
);

   localparam int unsigned TABLE_END = TABLE_BASE + (NUM_ENTRIES << STRIDE_LOG2);

   logic             rd_in_tab;
   logic [4:0]       rd_word;
   logic [NUM_ENTRIES-1:0] below_mask;

   always_comb begin
      rd_in_tab  = (32'(rd_addr) >= TABLE_BASE) && (32'(rd_addr) < TABLE_END);
      rd_word    = 5'(32'(rd_addr) - TABLE_BASE);
      below_mask = (NUM_ENTRIES'(1) << hit_entry) - NUM_ENTRIES'(1);
   end

   // R1: reset leaves every window idle
   assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !hit);

   // R8: a miss passes the address through
   assert_miss_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (xlat_addr == axi_addr));

   // R4: hit flag agrees with the per-window compare results
   assert_hit_from_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit == (|match_vec));

   // R7: the reported window matches and no lower window matches
   assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (match_vec[hit_entry] && ((match_vec & below_mask) == '0)));

   // R5: the smallest window is two bytes, so bit 0 always passes through
   assert_lsb_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (xlat_addr[0] == axi_addr[0]));

   // R10: without a write, readback and lookup hold while their inputs hold
   assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (!$stable(rd_addr) || $stable(rd_data)));
   assert_lookup_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (!$stable(axi_addr) || ($stable(hit) && $stable(xlat_addr))));

   // R3: reserved bits read zero
   assert_src_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_in_tab && rd_word == 5'h00) |-> (rd_data[11:7] == 5'd0));
   assert_trsl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_in_tab && rd_word == 5'h08) |-> (rd_data[11:0] == 12'd0));

endmodule

bind axi_pcie_atu atu_checker #(
   .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .CFG_AW(CFG_AW),
   .TABLE_BASE(TABLE_BASE), .STRIDE_LOG2(STRIDE_LOG2), .IDX_W(IDX_W)
) u_atu_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (cfg_wr_en),
   .rd_addr   (cfg_rd_addr),
   .rd_data   (cfg_rd_data),
   .axi_addr  (axi_addr_i),
   .hit       (hit_o),
   .xlat_addr (xlat_addr_o),
   .hit_entry (xlat_entry_o),
   .match_vec (match_vec)
);

// File: tb/tb_axi_pcie_atu.sv
module tb_axi_pcie_atu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [11:0] cfg_wr_addr = '0;
   logic [31:0] cfg_wr_data = '0;
   logic [11:0] cfg_rd_addr = '0;
   logic [31:0] cfg_rd_data;
   logic [63:0] axi_addr_i = '0;
   logic        hit_o;
   logic [63:0] xlat_addr_o;
   logic [3:0]  xlat_id_o;
   logic        xlat_dir_o;
   logic [2:0]  xlat_entry_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   axi_pcie_atu dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
      .axi_addr_i(axi_addr_i), .hit_o(hit_o), .xlat_addr_o(xlat_addr_o),
      .xlat_id_o(xlat_id_o), .xlat_dir_o(xlat_dir_o), .xlat_entry_o(xlat_entry_o)
   );

   function automatic logic [11:0] ea(input int n, input int off);
      return 12'('h800 + n * 'h20 + off);
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en   = 1'b1;
      cfg_wr_addr = a;
      cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en   = 1'b0;
   endtask

   task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
      cfg_rd_addr = a;
      #1;
      d = cfg_rd_data;
   endtask

   task automatic prog(input int n, input logic [63:0] src, input int s, input bit en,
                       input logic [63:0] trsl, input logic [31:0] prm);
      wr_reg(ea(n, 'h4), src[63:32]);
      wr_reg(ea(n, 'h8), trsl[31:0]);
      wr_reg(ea(n, 'hC), trsl[63:32]);
      wr_reg(ea(n, 'h10), prm);
      wr_reg(ea(n, 'h0), {src[31:12], 5'd0, 6'(s), en});
   endtask

   task automatic look(input logic [63:0] a);
      axi_addr_i = a;
      #1;
   endtask

   task automatic expect_hit(input string tag, input logic [63:0] a, input logic [63:0] xa,
                             input int ent, input int id, input bit dir);
      look(a);
      chk({tag, " hit"}, 64'(hit_o), 64'd1);
      chk({tag, " addr"}, xlat_addr_o, xa);
      chk({tag, " entry"}, 64'(xlat_entry_o), 64'(ent));
      chk({tag, " id"}, 64'(xlat_id_o), 64'(id));
      chk({tag, " dir"}, 64'(xlat_dir_o), 64'(dir));
   endtask

   task automatic expect_miss(input string tag, input logic [63:0] a);
      look(a);
      chk({tag, " hit"}, 64'(hit_o), 64'd0);
      chk({tag, " addr"}, xlat_addr_o, a);
      chk({tag, " id"}, 64'(xlat_id_o), 64'd0);
      chk({tag, " entry"}, 64'(xlat_entry_o), 64'd0);
   endtask

   // R1
   task automatic t_reset();
      logic [31:0] d;
      expect_miss("R1 reset lookup", 64'h1234_5678_9ABC_DEF0);
      rd_reg(ea(0, 0), d);
      chk("R1 reset src lo", 64'(d), 0);
      rd_reg(ea(7, 'h10), d);
      chk("R1 reset param", 64'(d), 0);
   endtask

   // R2, R3
   task automatic t_readback();
      logic [31:0] d;
      wr_reg(ea(3, 'h0), 32'hFFFF_FFFE);
      wr_reg(ea(3, 'h4), 32'hA5A5_0001);
      wr_reg(ea(3, 'h8), 32'hFFFF_FFFF);
      wr_reg(ea(3, 'hC), 32'h1357_9BDF);
      wr_reg(ea(3, 'h10), 32'h0040_0001);
      rd_reg(ea(3, 'h0), d);  chk("R3 src lo reserved", 64'(d), 64'hFFFF_F07E);
      rd_reg(ea(3, 'h4), d);  chk("R2 src hi", 64'(d), 64'hA5A5_0001);
      rd_reg(ea(3, 'h8), d);  chk("R3 trsl lo low bits", 64'(d), 64'hFFFF_F000);
      rd_reg(ea(3, 'hC), d);  chk("R2 trsl hi", 64'(d), 64'h1357_9BDF);
      rd_reg(ea(3, 'h10), d); chk("R2 param", 64'(d), 64'h0040_0001);
      rd_reg(ea(2, 'h4), d);  chk("R2 neighbour untouched", 64'(d), 0);
      for (int k = 0; k < 5; k++) wr_reg(ea(3, 4 * k), 32'd0);
   endtask

   // R4, R5, R9
   task automatic t_basic();
      prog(2, 64'h40_1000_0000, 19, 1'b1, 64'h8000_0000, 32'h0);
      expect_hit("R4 R5 mem window", 64'h40_1003_4567, 64'h8003_4567, 2, 0, 1'b0);
      expect_hit("R5 window top", 64'h40_100F_FFFF, 64'h800F_FFFF, 2, 0, 1'b0);
      expect_miss("R4 above window", 64'h40_1010_0000);
      expect_miss("R4 below window", 64'h40_0FFF_FFFF);
   endtask

   // R6
   task automatic t_disable();
      wr_reg(ea(2, 'h0), 32'h1000_0026);
      expect_miss("R6 disabled window", 64'h40_1003_4567);
      wr_reg(ea(2, 'h0), 32'h1000_0027);
      expect_hit("R6 re-enabled", 64'h40_1003_4567, 64'h8003_4567, 2, 0, 1'b0);
   endtask

   // R7, R9
   task automatic t_priority();
      prog(5, 64'h40_0000_0000, 31, 1'b1, 64'h1_0000_0000, 32'h0040_0000);
      expect_hit("R7 lower entry wins", 64'h40_1003_4567, 64'h8003_4567, 2, 0, 1'b0);
      expect_hit("R9 wide window dir", 64'h40_2000_0000, 64'h1_2000_0000, 5, 0, 1'b1);
      prog(0, 64'h40_1000_0000, 11, 1'b1, 64'hDEAD_B000, 32'h0);
      expect_hit("R7 entry 0 wins", 64'h40_1000_0123, 64'hDEAD_B123, 0, 0, 1'b0);
   endtask

   // R11, R9
   task automatic t_config();
      prog(7, 64'h9000_0000, 27, 1'b1, 64'h0, 32'h1);
      expect_hit("R11 config window", 64'h9123_4567, 64'h0123_4567, 7, 1, 1'b0);
      expect_miss("R11 past config window", 64'hA000_0000);
   endtask

   // R10
   task automatic t_latency();
      wr_reg(ea(6, 'h4), 32'h0);
      wr_reg(ea(6, 'h8), 32'h0);
      wr_reg(ea(6, 'hC), 32'h2);
      @(negedge clk);
      cfg_wr_en   = 1'b1;
      cfg_wr_addr = ea(6, 'h0);
      cfg_wr_data = 32'h5000_001F;   // S = 15, enabled
      axi_addr_i  = 64'h5000_ABCD;
      #1;
      chk("R10 before edge hit", 64'(hit_o), 64'd0);
      chk("R10 before edge addr", xlat_addr_o, 64'h5000_ABCD);
      @(posedge clk);
      #1;
      cfg_wr_en = 1'b0;
      chk("R10 after edge hit", 64'(hit_o), 64'd1);
      chk("R10 after edge addr", xlat_addr_o, 64'h2_0000_ABCD);
      chk("R10 after edge entry", 64'(xlat_entry_o), 64'd6);
   endtask

   // R12
   task automatic t_unmapped();
      logic [31:0] d;
      wr_reg(12'h900, 32'hFFFF_FFFF);
      wr_reg(ea(0, 'h14), 32'hFFFF_FFFF);
      wr_reg(12'h000, 32'hB000_0035);
      wr_reg(12'h7FC, 32'hB000_0035);
      rd_reg(12'h900, d);      chk("R12 beyond table reads zero", 64'(d), 0);
      rd_reg(ea(0, 'h14), d);  chk("R12 unused word reads zero", 64'(d), 0);
      rd_reg(ea(0, 'h0), d);   chk("R12 entry 0 src lo kept", 64'(d), 64'h1000_0017);
      rd_reg(ea(1, 'h0), d);   chk("R12 entry 1 src lo kept", 64'(d), 0);
      expect_miss("R12 lookup unchanged", 64'hB000_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_basic();
      t_disable();
      t_priority();
      t_config();
      t_latency();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule